// File: doc/BRIEF.md
# Serial Port Command Strobe Controller

This block sits between a simple register-write port and the datapath of a serial port. Software writes a 32-bit command word in which every bit is a strobe: a 1 requests an action and a 0 requests nothing. The block turns each accepted word into lasting on/off states and into one-cycle action pulses. The lasting states are transmitter enable, receiver enable, FIFO enable and the request-to-send (RTS) level. The pulses are datapath resets, FIFO flushes and a transmit-lock release. A write-protect input blocks every write while it is high.

The block also keeps two sticky flag sets, five error flags and eight FIFO event flags. Event pulses from the datapath set these flags, and one command bit clears them. A send-address strobe arms a flag. The next character written to the transmit holding register is then marked with its address bit, if the port is in multidrop mode at that moment.

Each on/off state is a two-state machine (`ST_OFF`, `ST_ON`). The transitions are `ST_OFF -> ST_ON` on an enable strobe and `ST_ON -> ST_OFF` on a disable strobe. The address-arm machine uses the same two states. Its set is the send-address strobe and its clear is a holding-register write. When set and clear arrive in the same cycle, the set wins.

Top module: `uscmd_ctrl`

## Requirements
- R1: After asynchronous reset the transmitter, receiver and FIFOs are off, the address flag is disarmed, all pulses are low, both flag sets are zero, and RTS is at the inactive level for the current mode.
- R2: While `wp_en` is high, a write (`wr_en` high) changes no state, produces no pulse, clears no flag and arms nothing.
- R3: Bit 6 turns the transmitter on unless bit 7 is also 1. Bit 7 always turns it off. A word with both bits 0 leaves it unchanged. The change is visible after the clock edge that accepts the write.
- R4: Bit 4 turns the receiver on unless bit 5 is also 1. Bit 5 always turns it off. A word with both bits 0 leaves it unchanged.
- R5: Bit 18 asserts RTS and bit 19 deasserts it, and bit 19 wins when both are set. When `mode` equals 2, asserted RTS drives `rts_o` high and deasserted RTS drives it low. For any other mode value, including 0, the levels are inverted.
- R6: Bit 30 turns both FIFOs on unless bit 31 is also 1. Bit 31 always turns them off.
- R7: The following bits each give a pulse that is high for exactly the one cycle after the write: bit 3 transmitter reset, bit 2 receiver reset, bit 24 transmit FIFO flush, bit 25 receive FIFO flush, and bit 26 transmit lock release.
- R8: A high bit on `err_evt_i` or `fifo_evt_i` sets the matching flag from the next cycle on. The flag stays set until it is cleared.
- R9: Bit 8 clears all error and FIFO event flags together. An event arriving in the same cycle as the clear leaves its flag set.
- R10: Bit 12 arms the address flag. On the next `thr_wr` the block pulses `chr_addr_o` for one cycle if `multidrop` is high, and disarms the flag whether or not `multidrop` is high. A `thr_wr` in the same cycle as the arming write is sent without the address bit, and the flag stays armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Command word write strobe |
| wr_data | input | 32 | Command word |
| wp_en | input | 1 | Write protect, blocks all writes |
| mode | input | 4 | Serial mode field (2 selects the high-active RTS polarity) |
| multidrop | input | 1 | Multidrop mode active |
| thr_wr | input | 1 | A character is written to the transmit holding register |
| err_evt_i | input | 5 | Error event pulses (parity, framing, overrun, break, compare) |
| fifo_evt_i | input | 8 | FIFO event pulses |
| tx_en_o | output | 1 | Transmitter enabled |
| rx_en_o | output | 1 | Receiver enabled |
| fifo_en_o | output | 1 | FIFOs enabled |
| rts_o | output | 1 | RTS pin level |
| tx_rst_o | output | 1 | Transmitter reset pulse |
| rx_rst_o | output | 1 | Receiver reset pulse |
| txf_flush_o | output | 1 | Transmit FIFO flush pulse |
| rxf_flush_o | output | 1 | Receive FIFO flush pulse |
| tx_unlock_o | output | 1 | Transmit FIFO lock release pulse |
| chr_addr_o | output | 1 | Address bit for the character just written |
| err_flags_o | output | 5 | Sticky error flags |
| fifo_flags_o | output | 8 | Sticky FIFO event flags |

## Verification
The hardest situations to reach are the same-cycle collisions. These are an enable and a disable in one word, an event together with the flag clear, and an arming write together with a holding-register write. Each one needs several inputs lined up in a single cycle. The driver builds these words on purpose and follows each with an idle cycle, so the outcome is visible. The address flag is also tested with `multidrop` low, to show that the flag is consumed without producing an address bit. The RTS checks change `mode` while the RTS state is held, which shows that the output level follows the mode.

// File: rtl/uscmd_pkg.sv
package uscmd_pkg;
    // command word bit positions (software-visible layout)
    localparam int B_RX_RST   = 2;
    localparam int B_TX_RST   = 3;
    localparam int B_RX_ON    = 4;
    localparam int B_RX_OFF   = 5;
    localparam int B_TX_ON    = 6;
    localparam int B_TX_OFF   = 7;
    localparam int B_CLR_STAT = 8;
    localparam int B_ARM_ADDR = 12;
    localparam int B_RTS_ON   = 18;
    localparam int B_RTS_OFF  = 19;
    localparam int B_TXF_FL   = 24;
    localparam int B_RXF_FL   = 25;
    localparam int B_TX_UNLK  = 26;
    localparam int B_FIFO_ON  = 30;
    localparam int B_FIFO_OFF = 31;

    // on/off machine indices
    localparam int EN_TX   = 0;
    localparam int EN_RX   = 1;
    localparam int EN_FIFO = 2;
    localparam int EN_RTS  = 3;
    localparam int EN_N    = 4;

    // pulse indices
    localparam int PL_TXRST = 0;
    localparam int PL_RXRST = 1;
    localparam int PL_TXFL  = 2;
    localparam int PL_RXFL  = 3;
    localparam int PL_UNLK  = 4;
    localparam int PL_N     = 5;

    typedef enum logic {ST_OFF = 1'b0, ST_ON = 1'b1} en_state_e;

    typedef struct packed {
        logic [EN_N-1:0] en_set;
        logic [EN_N-1:0] en_clr;
        logic [PL_N-1:0] pulse;
        logic            clr_stat;
        logic            arm_addr;
    } cmd_t;
endpackage

// File: rtl/uscmd_decode.sv
module uscmd_decode
    import uscmd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              wr_en,
    input  logic              wp_en,
    input  logic [DATA_W-1:0] wr_data,
    output cmd_t              cmd
);
    logic take;

    always_comb begin
        take = wr_en && !wp_en;
        cmd  = '0;
        if (take) begin
            cmd.en_set[EN_TX]   = wr_data[B_TX_ON];
            cmd.en_clr[EN_TX]   = wr_data[B_TX_OFF];
            cmd.en_set[EN_RX]   = wr_data[B_RX_ON];
            cmd.en_clr[EN_RX]   = wr_data[B_RX_OFF];
            cmd.en_set[EN_FIFO] = wr_data[B_FIFO_ON];
            cmd.en_clr[EN_FIFO] = wr_data[B_FIFO_OFF];
            cmd.en_set[EN_RTS]  = wr_data[B_RTS_ON];
            cmd.en_clr[EN_RTS]  = wr_data[B_RTS_OFF];
            cmd.pulse[PL_TXRST] = wr_data[B_TX_RST];
            cmd.pulse[PL_RXRST] = wr_data[B_RX_RST];
            cmd.pulse[PL_TXFL]  = wr_data[B_TXF_FL];
            cmd.pulse[PL_RXFL]  = wr_data[B_RXF_FL];
            cmd.pulse[PL_UNLK]  = wr_data[B_TX_UNLK];
            cmd.clr_stat        = wr_data[B_CLR_STAT];
            cmd.arm_addr        = wr_data[B_ARM_ADDR];
        end
    end
endmodule

// File: rtl/uscmd_enfsm.sv
module uscmd_enfsm
    import uscmd_pkg::*;
#(
    parameter bit SET_WINS = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic on_o
);
    en_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF: if (set_i && (SET_WINS || !clr_i)) state_nx = ST_ON;
            ST_ON:  if (clr_i && !(SET_WINS && set_i)) state_nx = ST_OFF;
            default: state_nx = ST_OFF;
        endcase
    end

    always_comb on_o = (state == ST_ON);
endmodule

// File: rtl/uscmd_pulse.sv
module uscmd_pulse #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= d_i;
    end
endmodule

// File: rtl/uscmd_sticky.sv
module uscmd_sticky #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] flags_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_o <= '0;
        else        flags_o <= (flags_o & ~{W{clr_i}}) | set_i;
    end
endmodule

// File: rtl/uscmd_ctrl.sv
module uscmd_ctrl
    import uscmd_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int MODE_W  = 4,
    parameter int MODE_HI = 2,
    parameter int ERR_W   = 5,
    parameter int FEV_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wp_en,
    input  logic [MODE_W-1:0] mode,
    input  logic              multidrop,
    input  logic              thr_wr,
    input  logic [ERR_W-1:0]  err_evt_i,
    input  logic [FEV_W-1:0]  fifo_evt_i,
    output logic              tx_en_o,
    output logic              rx_en_o,
    output logic              fifo_en_o,
    output logic              rts_o,
    output logic              tx_rst_o,
    output logic              rx_rst_o,
    output logic              txf_flush_o,
    output logic              rxf_flush_o,
    output logic              tx_unlock_o,
    output logic              chr_addr_o,
    output logic [ERR_W-1:0]  err_flags_o,
    output logic [FEV_W-1:0]  fifo_flags_o
);
    localparam logic [MODE_W-1:0] MODE_HI_V = MODE_W'(MODE_HI);

    cmd_t            cmd;
    logic [EN_N-1:0] en_on;
    logic [PL_N-1:0] pulses;
    logic            armed;

    uscmd_decode #(.DATA_W(DATA_W)) dec_i (
        .wr_en  (wr_en),
        .wp_en  (wp_en),
        .wr_data(wr_data),
        .cmd    (cmd)
    );

    for (genvar g = 0; g < EN_N; g++) begin : g_en
        uscmd_enfsm #(.SET_WINS(1'b0)) fsm_i (
            .clk  (clk),
            .rst_n(rst_n),
            .set_i(cmd.en_set[g]),
            .clr_i(cmd.en_clr[g]),
            .on_o (en_on[g])
        );
    end

    uscmd_enfsm #(.SET_WINS(1'b1)) arm_i (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(cmd.arm_addr),
        .clr_i(thr_wr),
        .on_o (armed)
    );

    uscmd_pulse #(.W(PL_N)) pul_i (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (cmd.pulse),
        .q_o  (pulses)
    );

    uscmd_sticky #(.W(ERR_W)) err_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (err_evt_i),
        .clr_i  (cmd.clr_stat),
        .flags_o(err_flags_o)
    );

    uscmd_sticky #(.W(FEV_W)) fev_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (fifo_evt_i),
        .clr_i  (cmd.clr_stat),
        .flags_o(fifo_flags_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chr_addr_o <= 1'b0;
        else        chr_addr_o <= thr_wr && armed && multidrop;
    end

    always_comb begin
        tx_en_o     = en_on[EN_TX];
        rx_en_o     = en_on[EN_RX];
        fifo_en_o   = en_on[EN_FIFO];
        rts_o       = (mode == MODE_HI_V) ? en_on[EN_RTS] : !en_on[EN_RTS];
        tx_rst_o    = pulses[PL_TXRST];
        rx_rst_o    = pulses[PL_RXRST];
        txf_flush_o = pulses[PL_TXFL];
        rxf_flush_o = pulses[PL_RXFL];
        tx_unlock_o = pulses[PL_UNLK];
    end
endmodule

// File: rtl/uscmd_ctrl_chk.sv
module uscmd_ctrl_chk #(
    parameter int DATA_W = 32,
    parameter int MODE_W = 4,
    parameter int ERR_W  = 5,
    parameter int FEV_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              wp_en,
    input logic [MODE_W-1:0] mode,
    input logic              multidrop,
    input logic              thr_wr,
    input logic [ERR_W-1:0]  err_evt_i,
    input logic [FEV_W-1:0]  fifo_evt_i,
    input logic              tx_en_o,
    input logic              rx_en_o,
    input logic              fifo_en_o,
    input logic              rts_o,
    input logic              tx_rst_o,
    input logic              rx_rst_o,
    input logic              txf_flush_o,
    input logic              rxf_flush_o,
    input logic              tx_unlock_o,
    input logic              chr_addr_o,
    input logic [ERR_W-1:0]  err_flags_o,
    input logic [FEV_W-1:0]  fifo_flags_o
);
    p_wp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wp_en) |=> ($stable(tx_en_o) && $stable(rx_en_o) && $stable(fifo_en_o)
                              && !tx_rst_o && !rx_rst_o && !txf_flush_o));

    p_txoff_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wp_en && wr_data[7]) |=> !tx_en_o);

    p_rxoff_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wp_en && wr_data[5]) |=> !rx_en_o);

    p_rts_off_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wp_en && wr_data[19]) |=> (mode != 4'd2 || !rts_o));

    p_fifooff_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wp_en && wr_data[31]) |=> !fifo_en_o);

    p_txrst_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rst_o |-> $past(wr_en && !wp_en && wr_data[3]));

    p_evt_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_evt_i != '0) |=> ((err_flags_o & $past(err_evt_i)) == $past(err_evt_i)));

    p_evt_beats_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_evt_i != '0) |=> ((fifo_flags_o & $past(fifo_evt_i)) == $past(fifo_evt_i)));

    p_addr_needs_thr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        chr_addr_o |-> $past(thr_wr && multidrop));
endmodule

bind uscmd_ctrl uscmd_ctrl_chk chk_i (.*);

// File: tb/uscmd_ctrl_tb_top.sv
module uscmd_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wp_en = 1'b0;
    logic [3:0]  mode = '0;
    logic        multidrop = 1'b0;
    logic        thr_wr = 1'b0;
    logic [4:0]  err_evt_i = '0;
    logic [7:0]  fifo_evt_i = '0;
    logic tx_en_o, rx_en_o, fifo_en_o, rts_o, tx_rst_o, rx_rst_o;
    logic txf_flush_o, rxf_flush_o, tx_unlock_o, chr_addr_o;
    logic [4:0] err_flags_o;
    logic [7:0] fifo_flags_o;

    always #10 clk = ~clk;   // 50 MHz

    uscmd_ctrl dut_i (.*);

    typedef struct {
        logic [22:0] exp;
        string       req;
    } item_t;
    item_t sb_q[$];

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // bench model state
    bit m_tx, m_rx, m_fifo, m_rts, m_arm;
    logic [4:0] m_err;
    logic [7:0] m_ff;

    function automatic logic [22:0] pack_exp(bit txr, bit rxr, bit tfl, bit rfl,
                                             bit unl, bit chr, logic [3:0] md);
        bit rts_lvl;
        rts_lvl = (md == 4'd2) ? m_rts : !m_rts;
        return {m_tx, m_rx, m_fifo, rts_lvl, txr, rxr, tfl, rfl, unl, chr, m_err, m_ff};
    endfunction

    task automatic model_reset();
        m_tx = 0; m_rx = 0; m_fifo = 0; m_rts = 0; m_arm = 0;
        m_err = '0; m_ff = '0;
    endtask

    // drive one cycle at the falling edge and push the expected outputs
    task automatic apply(bit we, logic [31:0] d, bit wp, logic [3:0] md, bit mdrop,
                         bit thr, logic [4:0] ee, logic [7:0] fe, string req);
        item_t it;
        bit ok, chr;
        @(negedge clk);
        wr_en = we; wr_data = d; wp_en = wp; mode = md; multidrop = mdrop;
        thr_wr = thr; err_evt_i = ee; fifo_evt_i = fe;
        ok  = we && !wp;
        chr = thr && m_arm && mdrop;
        if (ok && d[7]) m_tx = 0; else if (ok && d[6]) m_tx = 1;
        if (ok && d[5]) m_rx = 0; else if (ok && d[4]) m_rx = 1;
        if (ok && d[31]) m_fifo = 0; else if (ok && d[30]) m_fifo = 1;
        if (ok && d[19]) m_rts = 0; else if (ok && d[18]) m_rts = 1;
        if (ok && d[12]) m_arm = 1; else if (thr) m_arm = 0;
        if (ok && d[8]) begin m_err = '0; m_ff = '0; end
        m_err = m_err | ee;
        m_ff  = m_ff | fe;
        it.exp = pack_exp(ok && d[3], ok && d[2], ok && d[24], ok && d[25], ok && d[26], chr, md);
        it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic idle(logic [3:0] md, bit mdrop, string req);
        apply(0, '0, 0, md, mdrop, 0, '0, '0, req);
    endtask

    // monitor: sample 5 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb_q.size() > 0) begin
                item_t it;
                logic [22:0] act;
                it  = sb_q.pop_front();
                act = {tx_en_o, rx_en_o, fifo_en_o, rts_o, tx_rst_o, rx_rst_o,
                       txf_flush_o, rxf_flush_o, tx_unlock_o, chr_addr_o,
                       err_flags_o, fifo_flags_o};
                n_vec++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
                end
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state, mode 0 -> RTS inactive is high
        idle(4'd0, 0, "R1");
        // R3 transmitter
        apply(1, 32'h40, 0, 0, 0, 0, '0, '0, "R3 enable");
        apply(1, 32'h0, 0, 0, 0, 0, '0, '0, "R3 zero word");
        apply(1, 32'hC0, 0, 0, 0, 0, '0, '0, "R3 off wins while on");
        apply(1, 32'hC0, 0, 0, 0, 0, '0, '0, "R3 off wins while off");
        apply(1, 32'h40, 0, 0, 0, 0, '0, '0, "R3 re-enable");
        // R4 receiver
        apply(1, 32'h10, 0, 0, 0, 0, '0, '0, "R4 enable");
        apply(1, 32'h30, 0, 0, 0, 0, '0, '0, "R4 off wins");
        // R2 write protect
        apply(1, 32'hC000_01BC, 1, 0, 0, 0, '0, '0, "R2 protected write");
        idle(0, 0, "R2 after protected write");
        // R6 FIFOs
        apply(1, 32'h4000_0000, 0, 0, 0, 0, '0, '0, "R6 enable");
        apply(1, 32'hC000_0000, 0, 0, 0, 0, '0, '0, "R6 off wins");
        // R5 RTS polarity
        idle(4'd2, 0, "R5 mode2 inactive low");
        apply(1, 32'h0004_0000, 0, 2, 0, 0, '0, '0, "R5 mode2 assert high");
        idle(4'd0, 0, "R5 mode0 asserted low");
        apply(1, 32'h000C_0000, 0, 2, 0, 0, '0, '0, "R5 off wins mode2");
        apply(1, 32'h0004_0000, 0, 0, 0, 0, '0, '0, "R5 mode0 assert low");
        apply(1, 32'h0008_0000, 0, 0, 0, 0, '0, '0, "R5 mode0 deassert high");
        // R7 pulses
        apply(1, 32'h0700_000C, 0, 0, 0, 0, '0, '0, "R7 all pulses");
        idle(0, 0, "R7 pulses drop");
        apply(1, 32'h0000_0008, 0, 0, 0, 0, '0, '0, "R7 tx reset alone");
        idle(0, 0, "R7 single cycle");
        // R8 sticky flags
        apply(0, '0, 0, 0, 0, 0, 5'b00101, 8'h81, "R8 events");
        idle(0, 0, "R8 flags held");
        apply(0, '0, 0, 0, 0, 0, 5'b10000, 8'h00, "R8 accumulate");
        // R2 protected clear
        apply(1, 32'h100, 1, 0, 0, 0, '0, '0, "R2 protected clear");
        // R9 clear with colliding event
        apply(1, 32'h100, 0, 0, 0, 0, 5'b00010, 8'h10, "R9 clear, event wins");
        apply(1, 32'h100, 0, 0, 0, 0, '0, '0, "R9 clear all");
        // R10 send address
        apply(1, 32'h1000, 0, 0, 1, 0, '0, '0, "R10 arm");
        apply(0, '0, 0, 0, 1, 1, '0, '0, "R10 addr char");
        apply(0, '0, 0, 0, 1, 1, '0, '0, "R10 next char plain");
        apply(1, 32'h1000, 0, 0, 0, 0, '0, '0, "R10 arm no multidrop");
        apply(0, '0, 0, 0, 0, 1, '0, '0, "R10 consumed without bit");
        apply(0, '0, 0, 0, 1, 1, '0, '0, "R10 disarmed");
        apply(1, 32'h1000, 0, 0, 1, 1, '0, '0, "R10 arm and char same cycle");
        apply(0, '0, 0, 0, 1, 1, '0, '0, "R10 still armed");
        apply(1, 32'h1000, 1, 0, 1, 0, '0, '0, "R2 protected arm");
        apply(0, '0, 0, 0, 1, 1, '0, '0, "R2 no arm taken");
        idle(0, 0, "R1 drain");
        wait (sb_q.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule